// File: doc/BRIEF.md
# Diagnostic Threshold Flag Comparator

This block watches five live 16-bit monitor readings of an optical link module: internal temperature, supply voltage, transmitter bias current, transmitter optical power and received optical power. It compares each reading against four programmable limits: a high alarm, a low alarm, a high warning and a low warning. From the results it builds the packed flag bytes that the host reads back through the diagnostic register space. The limits arrive as a flat 40-byte image and the readings as a flat 10-byte image, both big-endian. The register storage that holds these images lives outside this block.

Temperature is signed two's complement in 1/256 °C steps. For example, 0x5500 is +85 °C and 0xD800 is -40 °C. The other four readings are unsigned: supply in 100 µV steps, bias in 2 µA steps, and both optical powers in 0.1 µW steps. When the measurement side has a fresh set of readings, it pulses a strobe. On that strobe all twenty comparisons are captured into the flag registers, and the flags then hold until the next strobe.

Top module: `diag_flag_cmp`

## Requirements
- R1: After reset all four flag bytes are 0x00.
- R2: While `smp_vld` is low, the flag outputs do not change, even when the readings or limits change.
- R3: Limit image byte k sits at `lim_img[8k+7:8k]`. Each limit is a pair of bytes with the most significant byte at the even offset. For quantity q (0 temperature, 1 supply, 2 bias, 3 tx power, 4 rx power) and level l (0 high alarm, 1 low alarm, 2 high warning, 3 low warning), the limit starts at byte 8q+2l.
- R4: Reading image byte k sits at `rd_img[8k+7:8k]`. Quantity q is the pair starting at byte 2q, with the most significant byte first.
- R5: The temperature comparisons treat both the reading and the limit as signed two's complement.
- R6: The supply, bias and both power comparisons are unsigned.
- R7: A high flag is set only when the reading is strictly greater than its high limit. Equality does not set it.
- R8: A low flag is set only when the reading is strictly less than its low limit. Equality does not set it.
- R9: In `alm_flg_a`, bits 7 down to 0 are: temperature high, temperature low, supply high, supply low, bias high, bias low, tx power high, tx power low.
- R10: In `alm_flg_b`, bit 7 is rx power high and bit 6 is rx power low. Bits 5 to 0 are always 0.
- R11: `wrn_flg_a` and `wrn_flg_b` use the same bit layout as the alarm bytes, but are compared against the warning limits (levels 2 and 3).
- R12: Flags sampled on a clock edge with `smp_vld` high appear on the outputs right after that edge. Before that edge the outputs still show the previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Fresh-reading strobe; captures new flags |
| lim_img | input | 320 | 40-byte limit image |
| rd_img | input | 80 | 10-byte live reading image |
| alm_flg_a | output | 8 | Alarm flags, first byte |
| alm_flg_b | output | 8 | Alarm flags, second byte |
| wrn_flg_a | output | 8 | Warning flags, first byte |
| wrn_flg_b | output | 8 | Warning flags, second byte |

## Verification
The hardest behaviour to reach from the ports is a reading sitting exactly on a limit, or one step to either side of it. It is also hard to hit a temperature whose sign bit makes the signed and unsigned orderings disagree. Uniformly random 16-bit words almost never land there. For that reason the random stimulus often derives a reading from one of its own limits plus -1, 0 or +1. Directed cases then pit a negative temperature against the default limits and a large unsigned supply reading against a mid-range limit.

// File: rtl/diag_cmp_pkg.sv
package diag_cmp_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_HI_ALM = 0;
  localparam int unsigned LVL_LO_ALM = 1;
  localparam int unsigned LVL_HI_WRN = 2;
  localparam int unsigned LVL_LO_WRN = 3;

  typedef struct packed {
    logic hi_alm;
    logic lo_alm;
    logic hi_wrn;
    logic lo_wrn;
  } qty_flags_t;
endpackage

// File: rtl/diag_word_cmp.sv
module diag_word_cmp #(
  parameter int unsigned WORD_W    = 16,
  parameter bit          IS_SIGNED = 1'b0,
  parameter bit          CHK_BELOW = 1'b0
) (
  input  logic [WORD_W-1:0] val,
  input  logic [WORD_W-1:0] lim,
  output logic              hit
);
  generate
    if (IS_SIGNED && CHK_BELOW) begin : g_s_below
      assign hit = $signed(val) < $signed(lim);
    end else if (IS_SIGNED) begin : g_s_above
      assign hit = $signed(val) > $signed(lim);
    end else if (CHK_BELOW) begin : g_u_below
      assign hit = val < lim;
    end else begin : g_u_above
      assign hit = val > lim;
    end
  endgenerate
endmodule

// File: rtl/diag_qty_cmp.sv
module diag_qty_cmp
  import diag_cmp_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter bit          IS_SIGNED = 1'b0
) (
  input  logic [WORD_W-1:0]         val,
  input  logic [NUM_LVL*WORD_W-1:0] lim_set,
  output qty_flags_t                flags
);
  logic [NUM_LVL-1:0] lvl_hit;

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      diag_word_cmp #(
        .WORD_W   (WORD_W),
        .IS_SIGNED(IS_SIGNED),
        .CHK_BELOW((l % 2) == 1)
      ) u_cmp (
        .val(val),
        .lim(lim_set[l*WORD_W +: WORD_W]),
        .hit(lvl_hit[l])
      );
    end
  endgenerate

  assign flags.hi_alm = lvl_hit[LVL_HI_ALM];
  assign flags.lo_alm = lvl_hit[LVL_LO_ALM];
  assign flags.hi_wrn = lvl_hit[LVL_HI_WRN];
  assign flags.lo_wrn = lvl_hit[LVL_LO_WRN];
endmodule

// File: rtl/diag_flag_pack.sv
module diag_flag_pack
  import diag_cmp_pkg::*;
#(
  parameter int unsigned NUM_QTY = 5,
  parameter int unsigned OUT_W   = 16
) (
  input  qty_flags_t [NUM_QTY-1:0] q_flags,
  output logic [OUT_W-1:0]         alm_word,
  output logic [OUT_W-1:0]         wrn_word
);
  always_comb begin
    alm_word = '0;
    wrn_word = '0;
    for (int q = 0; q < NUM_QTY; q++) begin
      alm_word[OUT_W-1-2*q] = q_flags[q].hi_alm;
      alm_word[OUT_W-2-2*q] = q_flags[q].lo_alm;
      wrn_word[OUT_W-1-2*q] = q_flags[q].hi_wrn;
      wrn_word[OUT_W-2-2*q] = q_flags[q].lo_wrn;
    end
  end
endmodule

// File: rtl/diag_flag_cmp.sv
module diag_flag_cmp
  import diag_cmp_pkg::*;
#(
  parameter int unsigned        NUM_QTY     = 5,
  parameter int unsigned        WORD_W      = 16,
  parameter logic [NUM_QTY-1:0] SIGNED_MASK = 5'b00001,
  localparam int unsigned       BPW         = WORD_W / 8,
  localparam int unsigned       LIM_BYTES   = NUM_QTY * NUM_LVL * BPW,
  localparam int unsigned       RD_BYTES    = NUM_QTY * BPW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld,
  input  logic [LIM_BYTES*8-1:0] lim_img,
  input  logic [RD_BYTES*8-1:0]  rd_img,
  output logic [7:0]             alm_flg_a,
  output logic [7:0]             alm_flg_b,
  output logic [7:0]             wrn_flg_a,
  output logic [7:0]             wrn_flg_b
);
  localparam int unsigned OUT_W = 16;

  qty_flags_t [NUM_QTY-1:0] q_flags;
  logic [OUT_W-1:0] alm_d, wrn_d, alm_cmb, wrn_cmb;
  logic [OUT_W-1:0] alm_q, wrn_q;

  generate
    for (genvar q = 0; q < NUM_QTY; q++) begin : g_qty
      logic [WORD_W-1:0]         rd_word;
      logic [NUM_LVL*WORD_W-1:0] lim_set;

      always_comb begin
        for (int j = 0; j < BPW; j++) begin
          rd_word[WORD_W-1-8*j -: 8] = rd_img[(q*BPW + j)*8 +: 8];
        end
        for (int l = 0; l < NUM_LVL; l++) begin
          for (int j = 0; j < BPW; j++) begin
            lim_set[l*WORD_W + WORD_W-1-8*j -: 8] =
              lim_img[((q*NUM_LVL + l)*BPW + j)*8 +: 8];
          end
        end
      end

      diag_qty_cmp #(
        .WORD_W   (WORD_W),
        .IS_SIGNED(SIGNED_MASK[q])
      ) u_qty (
        .val    (rd_word),
        .lim_set(lim_set),
        .flags  (q_flags[q])
      );
    end
  endgenerate

  diag_flag_pack #(
    .NUM_QTY(NUM_QTY),
    .OUT_W  (OUT_W)
  ) u_pack (
    .q_flags (q_flags),
    .alm_word(alm_cmb),
    .wrn_word(wrn_cmb)
  );

  always_comb begin
    alm_d = alm_q;
    wrn_d = wrn_q;
    if (smp_vld) begin
      alm_d = alm_cmb;
      wrn_d = wrn_cmb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
      wrn_q <= '0;
    end else begin
      alm_q <= alm_d;
      wrn_q <= wrn_d;
    end
  end

  assign alm_flg_a = alm_q[15:8];
  assign alm_flg_b = alm_q[7:0];
  assign wrn_flg_a = wrn_q[15:8];
  assign wrn_flg_b = wrn_q[7:0];
endmodule

// File: rtl/diag_flag_cmp_chk.sv
module diag_flag_cmp_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_vld,
  input logic [319:0] lim_img,
  input logic [79:0]  rd_img,
  input logic [7:0]   alm_flg_a,
  input logic [7:0]   alm_flg_b,
  input logic [7:0]   wrn_flg_a,
  input logic [7:0]   wrn_flg_b
);
  logic [15:0] t_rd, t_hi, v_rd, v_lo;
  assign t_rd = {rd_img[7:0], rd_img[15:8]};
  assign t_hi = {lim_img[7:0], lim_img[15:8]};
  assign v_rd = {rd_img[23:16], rd_img[31:24]};
  assign v_lo = {lim_img[87:80], lim_img[95:88]};

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable({alm_flg_a, alm_flg_b, wrn_flg_a, wrn_flg_b})); // R2

  AST_TEMP_HI_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (alm_flg_a[7] == ($past($signed(t_rd)) > $past($signed(t_hi))))); // R5

  AST_VCC_LO_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (alm_flg_a[4] == ($past(v_rd) < $past(v_lo)))); // R6

  AST_ALM_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flg_b[5:0] == 6'd0); // R10

  AST_WRN_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrn_flg_b[5:0] == 6'd0); // R11
endmodule

bind diag_flag_cmp diag_flag_cmp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_vld  (smp_vld),
  .lim_img  (lim_img),
  .rd_img   (rd_img),
  .alm_flg_a(alm_flg_a),
  .alm_flg_b(alm_flg_b),
  .wrn_flg_a(wrn_flg_a),
  .wrn_flg_b(wrn_flg_b)
);

// File: tb/tb_diag_flag_cmp.sv
module tb_diag_flag_cmp;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_vld;
  logic [319:0] lim_img;
  logic [79:0]  rd_img;
  logic [7:0]   alm_flg_a, alm_flg_b, wrn_flg_a, wrn_flg_b;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  diag_flag_cmp dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .lim_img(lim_img), .rd_img(rd_img),
    .alm_flg_a(alm_flg_a), .alm_flg_b(alm_flg_b),
    .wrn_flg_a(wrn_flg_a), .wrn_flg_b(wrn_flg_b)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic void set_lim(int q, int l, logic [15:0] w);
    lim_img[(8*q+2*l)*8 +: 8]   = w[15:8];
    lim_img[(8*q+2*l+1)*8 +: 8] = w[7:0];
  endfunction

  function automatic logic [15:0] get_lim(int q, int l);
    return {lim_img[(8*q+2*l)*8 +: 8], lim_img[(8*q+2*l+1)*8 +: 8]};
  endfunction

  function automatic void set_rd(int q, logic [15:0] w);
    rd_img[(2*q)*8 +: 8]   = w[15:8];
    rd_img[(2*q+1)*8 +: 8] = w[7:0];
  endfunction

  function automatic logic [15:0] get_rd(int q);
    return {rd_img[(2*q)*8 +: 8], rd_img[(2*q+1)*8 +: 8]};
  endfunction

  function automatic bit above(logic [15:0] a, logic [15:0] b, bit sgn);
    if (sgn) return $signed(a) > $signed(b);
    return a > b;
  endfunction

  // Returns {alm_a, alm_b, wrn_a, wrn_b}
  function automatic logic [31:0] model();
    logic [15:0] alm = '0;
    logic [15:0] wrn = '0;
    for (int q = 0; q < 5; q++) begin
      bit sg = (q == 0);
      logic [15:0] v = get_rd(q);
      alm[15-2*q] = above(v, get_lim(q, 0), sg);
      alm[14-2*q] = above(get_lim(q, 1), v, sg);
      wrn[15-2*q] = above(v, get_lim(q, 2), sg);
      wrn[14-2*q] = above(get_lim(q, 3), v, sg);
    end
    return {alm, wrn};
  endfunction

  task automatic chk(string tag, logic [31:0] exp);
    logic [31:0] act = {alm_flg_a, alm_flg_b, wrn_flg_a, wrn_flg_b};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(string tag);
    logic [31:0] exp = model();
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    chk(tag, exp);
  endtask

  task automatic quiet_limits();
    for (int q = 0; q < 5; q++) begin
      set_lim(q, 0, (q == 0) ? 16'h7FFF : 16'hFFFF);
      set_lim(q, 1, (q == 0) ? 16'h8000 : 16'h0000);
      set_lim(q, 2, (q == 0) ? 16'h7FFF : 16'hFFFF);
      set_lim(q, 3, (q == 0) ? 16'h8000 : 16'h0000);
      set_rd(q, 16'h0100);
    end
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b1; smp_vld = 1'b0; lim_img = '0; rd_img = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: default temperature limits, hot reading
    quiet_limits();
    set_lim(0, 0, 16'h5500); set_lim(0, 1, 16'hD800);
    set_lim(0, 2, 16'h5000); set_lim(0, 3, 16'hDD00);
    set_rd(0, 16'h6000);
    strobe("R5 R9 temp hot");
    chk("R5 R11 hot exp", 32'h8000_8000);
    // R5: -64 C is below -40 C when signed
    set_rd(0, 16'hC000);
    strobe("R5 temp cold");
    chk("R5 cold exp", 32'h4000_4000);

    // R7 R8: reading equals every limit
    for (int q = 0; q < 5; q++) begin
      for (int l = 0; l < 4; l++) set_lim(q, l, 16'h1234);
      set_rd(q, 16'h1234);
    end
    strobe("R7 R8 equality");
    chk("R7 R8 equality none", 32'h0);

    // R6: large unsigned supply above mid limit
    quiet_limits();
    set_lim(1, 0, 16'h8000);
    set_rd(1, 16'hF000);
    strobe("R6 vcc unsigned");
    chk("R6 R9 vcc hi bit", 32'h2000_0000);

    // R10: rx power low alarm and warning
    quiet_limits();
    set_lim(4, 1, 16'h0200); set_lim(4, 3, 16'h0200);
    strobe("R10 rx low");
    chk("R10 R11 rx low bits", 32'h0040_0040);

    // R2: change inputs without strobe, flags held
    held = {alm_flg_a, alm_flg_b, wrn_flg_a, wrn_flg_b};
    quiet_limits();
    set_rd(0, 16'h7FFF); set_lim(0, 0, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R2 hold without strobe", held);

    // R12: before the capturing edge old value, after it new value
    smp_vld = 1'b1;
    #1;
    chk("R12 before edge", held);
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R12 after edge", model());

    // Random with near-limit readings: R3 R4 R9 R10 R11
    for (int i = 0; i < 400; i++) begin
      for (int q = 0; q < 5; q++) begin
        for (int l = 0; l < 4; l++) set_lim(q, l, 16'($urandom));
        if ($urandom_range(2) != 0)
          set_rd(q, get_lim(q, $urandom_range(3)) + 16'($urandom_range(2)) - 16'd1);
        else
          set_rd(q, 16'($urandom));
      end
      strobe("R3,R4,R9,R10,R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule